// File: doc/BRIEF.md
# Spare-Wire Vertical Link Repair Fabric

This block steers the logical signals of a vertical inter-die link onto working through-silicon wires. Each logical signal owns a pair of physical wires: a primary and a spare. A multiplexer crossbar on the transmit side places each signal on one wire of its pair. A matching crossbar on the receive side picks the same wire back out. Data and control signals are treated the same way.

The steering comes from repair data produced outside the chip. That data is held in a write-once configuration register, which stands in for one-time-programmable storage. The repair data is a mask with one bit per physical wire, and a set bit marks that wire as bad. Physical wire 2i is the primary of signal i and wire 2i+1 is its spare.

A small two-state machine guards the register. In state BLANK, after reset, the mask is all zeros and every signal uses its primary wire. The transition PROGRAM fires on the first write strobe in BLANK: it captures the mask and enters state BURNT. State BURNT has only one transition, HOLD, back to itself, so every later strobe is ignored. A status output flags each signal whose two wires are both marked bad.

Top module: `tsv_spare_repair`

## Requirements
- R1: After reset, `cfg_locked` is 0, every signal i drives `phy_tx[2i]` and reads `phy_rx[2i]`, all spare wires carry 0, and `fault_sig` and `fault_any` are 0.
- R2: A write strobe while `cfg_locked` is 0 stores `cfg_bad`. From the next cycle on, `cfg_locked` is 1 and the stored mask sets the steering.
- R3: A write strobe while `cfg_locked` is 1 has no effect. The steering, `fault_sig` and `cfg_locked` stay exactly as the first write left them.
- R4: Transmit side: when mask bit 2i is clear, `tx_sig[i]` appears on `phy_tx[2i]` and `phy_tx[2i+1]` is 0. When bit 2i is set, `tx_sig[i]` appears on `phy_tx[2i+1]` and `phy_tx[2i]` is 0.
- R5: Receive side: `rx_sig[i]` is `phy_rx[2i+1]` when mask bit 2i is set, and `phy_rx[2i]` otherwise.
- R6: `fault_sig[i]` is 1 exactly when mask bits 2i and 2i+1 are both set, and `fault_any` is the OR of all `fault_sig` bits.
- R7: A bad spare whose primary is good (bit 2i+1 set, bit 2i clear) leaves signal i on its primary wire and raises no fault.
- R8: Looping `phy_tx` back into `phy_rx` returns `rx_sig == tx_sig` for every stored mask, because both sides use the same steering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the repair mask |
| cfg_bad | input | 2*NUM_SIG | Repair mask, one bit per physical wire, 1 = bad |
| cfg_locked | output | 1 | 1 once the mask has been written |
| tx_sig | input | NUM_SIG | Logical signals to transmit |
| phy_tx | output | 2*NUM_SIG | Physical wires driven toward the other die |
| phy_rx | input | 2*NUM_SIG | Physical wires arriving from the other die |
| rx_sig | output | NUM_SIG | Logical signals recovered from the wires |
| fault_sig | output | NUM_SIG | Per-signal flag: both wires of the pair are bad |
| fault_any | output | 1 | OR of `fault_sig` |

## Verification
If the stored mask is wrong, or the state machine re-opens after BURNT, the fault shows on the ports in the first cycle after the write. A signal then appears on the wrong wire of its pair, an unused wire goes non-zero, `rx_sig` takes the other wire, or `fault_sig` changes. The steering is combinational from the stored mask, so any input vector applied after that edge exposes a bad bit in the cycle it is applied. A second write with a different mask is followed by vectors checked against the first mask. These vectors catch a lock that lets the second write through.

// File: rtl/tsv_repair_pkg.sv
package tsv_repair_pkg;

    typedef enum logic {
        FUSE_BLANK = 1'b0,
        FUSE_BURNT = 1'b1
    } fuse_state_e;

endpackage

// File: rtl/tsv_fuse_reg.sv
module tsv_fuse_reg
    import tsv_repair_pkg::*;
#(
    parameter int WIRES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIRES-1:0] wr_mask,
    output logic [WIRES-1:0] bad_mask,
    output logic             locked
);

    fuse_state_e state_q, state_d;

    // Next-state logic: PROGRAM moves BLANK to BURNT, HOLD keeps BURNT.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FUSE_BLANK: if (wr_en) state_d = FUSE_BURNT;
            FUSE_BURNT: state_d = FUSE_BURNT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FUSE_BLANK;
        else        state_q <= state_d;
    end

    // Mask storage: written only on the PROGRAM transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             bad_mask <= '0;
        else if (state_q == FUSE_BLANK && wr_en) bad_mask <= wr_mask;
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            FUSE_BLANK: locked = 1'b0;
            FUSE_BURNT: locked = 1'b1;
        endcase
    end

    // R2: the first write is captured and locks the register.
    a_r2_first_write_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && wr_en) |=> (locked && bad_mask == $past(wr_mask)));

    // R2: once locked, the register stays locked.
    a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R3: writes after locking leave the mask unchanged.
    a_r3_locked_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(bad_mask));

    // R1: before the first write, the mask is all zeros.
    a_r1_blank_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (bad_mask == '0));

endmodule

// File: rtl/tsv_pair_health.sv
module tsv_pair_health #(
    parameter int NUM_SIG = 8,
    localparam int WIRES  = 2 * NUM_SIG
) (
    input  logic [WIRES-1:0]   bad_mask,
    output logic [NUM_SIG-1:0] use_spare,
    output logic [NUM_SIG-1:0] fault_sig
);

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_pair
        always_comb begin
            use_spare[i] = bad_mask[2*i];
            fault_sig[i] = bad_mask[2*i] & bad_mask[2*i+1];
        end
    end

endmodule

// File: rtl/tsv_tx_steer.sv
module tsv_tx_steer #(
    parameter int NUM_SIG = 8,
    localparam int WIRES  = 2 * NUM_SIG
) (
    input  logic [NUM_SIG-1:0] sig_in,
    input  logic [NUM_SIG-1:0] use_spare,
    output logic [WIRES-1:0]   wire_out
);

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_tx
        always_comb begin
            wire_out[2*i]   = use_spare[i] ? 1'b0      : sig_in[i];
            wire_out[2*i+1] = use_spare[i] ? sig_in[i] : 1'b0;
        end
    end

endmodule

// File: rtl/tsv_rx_steer.sv
module tsv_rx_steer #(
    parameter int NUM_SIG = 8,
    localparam int WIRES  = 2 * NUM_SIG
) (
    input  logic [WIRES-1:0]   wire_in,
    input  logic [NUM_SIG-1:0] use_spare,
    output logic [NUM_SIG-1:0] sig_out
);

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_rx
        always_comb sig_out[i] = use_spare[i] ? wire_in[2*i+1] : wire_in[2*i];
    end

endmodule

// File: rtl/tsv_spare_repair.sv
module tsv_spare_repair #(
    parameter int NUM_SIG = 8,
    localparam int WIRES  = 2 * NUM_SIG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [WIRES-1:0]   cfg_bad,
    output logic               cfg_locked,
    input  logic [NUM_SIG-1:0] tx_sig,
    output logic [WIRES-1:0]   phy_tx,
    input  logic [WIRES-1:0]   phy_rx,
    output logic [NUM_SIG-1:0] rx_sig,
    output logic [NUM_SIG-1:0] fault_sig,
    output logic               fault_any
);

    logic [WIRES-1:0]   bad_mask;
    logic [NUM_SIG-1:0] use_spare;

    tsv_fuse_reg #(.WIRES(WIRES)) u_fuse (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_mask  (cfg_bad),
        .bad_mask (bad_mask),
        .locked   (cfg_locked)
    );

    tsv_pair_health #(.NUM_SIG(NUM_SIG)) u_health (
        .bad_mask  (bad_mask),
        .use_spare (use_spare),
        .fault_sig (fault_sig)
    );

    tsv_tx_steer #(.NUM_SIG(NUM_SIG)) u_tx (
        .sig_in    (tx_sig),
        .use_spare (use_spare),
        .wire_out  (phy_tx)
    );

    tsv_rx_steer #(.NUM_SIG(NUM_SIG)) u_rx (
        .wire_in   (phy_rx),
        .use_spare (use_spare),
        .sig_out   (rx_sig)
    );

    always_comb fault_any = |fault_sig;

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_chk
        // R4: at most one wire of a pair carries the signal.
        a_r4_one_wire_per_pair: assert property (@(posedge clk) disable iff (!rst_n)
            !(phy_tx[2*i] && phy_tx[2*i+1]));

        // R6: a dead pair has moved off its primary wire.
        a_r6_fault_off_primary: assert property (@(posedge clk) disable iff (!rst_n)
            fault_sig[i] |-> !phy_tx[2*i]);

        // R1: before programming, transmit uses the primary wire.
        a_r1_blank_tx_primary: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_locked |-> (phy_tx[2*i] == tx_sig[i] && !phy_tx[2*i+1]));

        // R5: before programming, receive reads the primary wire.
        a_r5_blank_rx_primary: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_locked |-> (rx_sig[i] == phy_rx[2*i]));
    end

endmodule

// File: tb/tsv_spare_repair_tb_top.sv
module tsv_spare_repair_tb_top;

    localparam int N = 8;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [W-1:0] cfg_bad = '0;
    logic         cfg_locked;
    logic [N-1:0] tx_sig = '0;
    logic [W-1:0] phy_tx;
    logic [W-1:0] phy_rx = '0;
    logic [N-1:0] rx_sig;
    logic [N-1:0] fault_sig;
    logic         fault_any;

    always #2.5 clk = ~clk;

    tsv_spare_repair #(.NUM_SIG(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bad(cfg_bad),
        .cfg_locked(cfg_locked), .tx_sig(tx_sig), .phy_tx(phy_tx),
        .phy_rx(phy_rx), .rx_sig(rx_sig), .fault_sig(fault_sig),
        .fault_any(fault_any)
    );

    typedef struct {
        logic [W-1:0] tx;
        logic [N-1:0] rx;
        logic [N-1:0] flt;
        logic         any;
        logic         lk;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           n_vec = 0;
    int           n_bad = 0;
    logic [W-1:0] m_bad = '0;
    logic         m_lock = 1'b0;
    bit           done = 1'b0;

    function automatic logic [W-1:0] exp_tx(logic [N-1:0] t, logic [W-1:0] m);
        logic [W-1:0] o = '0;
        for (int i = 0; i < N; i++) begin
            if (m[2*i]) o[2*i+1] = t[i];
            else        o[2*i]   = t[i];
        end
        return o;
    endfunction

    function automatic logic [N-1:0] exp_rx(logic [W-1:0] r, logic [W-1:0] m);
        logic [N-1:0] o;
        for (int i = 0; i < N; i++) o[i] = m[2*i] ? r[2*i+1] : r[2*i];
        return o;
    endfunction

    function automatic logic [N-1:0] exp_flt(logic [W-1:0] m);
        logic [N-1:0] o;
        for (int i = 0; i < N; i++) o[i] = m[2*i] & m[2*i+1];
        return o;
    endfunction

    // Driver: inputs change 1 ns after a rising edge; expectation queued.
    task automatic drive(input logic [N-1:0] t, input logic [W-1:0] r, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        tx_sig = t;
        phy_rx = r;
        e.tx  = exp_tx(t, m_bad);
        e.rx  = exp_rx(r, m_bad);
        e.flt = exp_flt(m_bad);
        e.any = |e.flt;
        e.lk  = m_lock;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic loopback(input logic [N-1:0] t, input string tag);
        drive(t, exp_tx(t, m_bad), tag);
    endtask

    task automatic write_cfg(input logic [W-1:0] m);
        @(posedge clk);
        #1;
        cfg_we  = 1'b1;
        cfg_bad = m;
        if (!m_lock) begin
            m_bad  = m;
            m_lock = 1'b1;
        end
        @(posedge clk);
        #1;
        cfg_we  = 1'b0;
        cfg_bad = '0;
    endtask

    // Monitor: samples at the falling edge, away from input changes.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                if (phy_tx !== e.tx) begin
                    n_bad++;
                    $display("FAIL %s phy_tx actual %h expected %h", e.tag, phy_tx, e.tx);
                end
                if (rx_sig !== e.rx) begin
                    n_bad++;
                    $display("FAIL %s rx_sig actual %h expected %h", e.tag, rx_sig, e.rx);
                end
                if (fault_sig !== e.flt || fault_any !== e.any) begin
                    n_bad++;
                    $display("FAIL %s fault actual %h/%b expected %h/%b",
                             e.tag, fault_sig, fault_any, e.flt, e.any);
                end
                if (cfg_locked !== e.lk) begin
                    n_bad++;
                    $display("FAIL %s cfg_locked actual %b expected %b", e.tag, cfg_locked, e.lk);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, primary wires only.
        drive(8'h00, 16'h0000, "R1 zero");
        drive(8'hA5, 16'hAAAA, "R1 pattern");
        drive(8'hFF, 16'h5555, "R1 all ones");
        loopback(8'h3C, "R8 loopback blank");

        // R2: first write captured.
        // Signal 0: primary bad (spare used). Signal 3: spare bad only (R7).
        // Signal 5: both bad (R6). Signal 7: primary bad.
        write_cfg(16'b0100_1100_1000_0001);
        drive(8'hFF, 16'h0000, "R2 R4 tx steer ones");
        drive(8'h81, 16'h0000, "R4 tx steer sparse");
        drive(8'h00, 16'hAAAA, "R5 rx from odd wires");
        drive(8'h00, 16'h5555, "R5 rx from even wires");
        drive(8'h08, 16'h0040, "R7 spare bad primary kept");
        drive(8'h20, 16'h0000, "R6 dead pair flagged");
        loopback(8'hC3, "R8 loopback programmed");
        loopback(8'h5A, "R8 loopback programmed b");

        // R3: second write with a different mask must be ignored.
        write_cfg(16'hFFFF);
        drive(8'hFF, 16'hAAAA, "R3 ignored write tx rx");
        drive(8'h01, 16'h0001, "R3 ignored write sig0");
        write_cfg(16'h0000);
        drive(8'h81, 16'h8002, "R3 ignored clear write");
        loopback(8'hFF, "R8 loopback after ignored");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule